// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a single-cycle processor core for a small load/store integer instruction subset. Every clock cycle it presents the program counter on an instruction-memory address port and takes one 32-bit instruction back combinationally. It decodes the instruction as register, immediate or jump format, and reads two operands from a 32-entry register file. It then computes a result and either writes it back, stores a register to the word-wide data-memory port, or loads a word from that port. A small next-PC unit inside the block chooses the following program counter.

The supported operations are add, sub, slt, addi, slti, andi, ori, lui, lw, sw, beq, bne, j, jal and jr. Constants wider than 16 bits are built from lui followed by ori. Comparisons produce a 0/1 value in a register instead of condition flags. Register 0 is hardwired to zero. Any opcode or function code outside the set writes nothing and falls through to the next word.

Top module: `risc_core`

## Requirements
- R1: A synchronous reset holds the program counter (`imem_addr`) at 0. After reset is released, each executed non-control instruction advances `imem_addr` by 4 on the next rising edge.
- R2: Register-format instructions have opcode 0 (bits 31:26), with source registers in bits 25:21 and 20:16 and the destination in bits 15:11. The function code in bits 5:0 selects the operation: 32 is add, 34 is subtract (first source minus second), and 42 is signed set-less-than.
- R3: addi (opcode 8) and slti (opcode 10) sign-extend the 16-bit immediate in bits 15:0. andi (opcode 12) and ori (opcode 13) zero-extend it. Each writes its result to the register in bits 20:16, and slti writes 1 when the source is signed-less-than the immediate, otherwise 0.
- R4: lui (opcode 15) writes the immediate into bits 31:16 of the target register and clears bits 15:0.
- R5: lw (opcode 35) loads the target register from the data word at the base register plus the sign-extended offset. sw (opcode 43) drives that address with the target register as write data and asserts `dmem_we`. `dmem_we` is asserted for no other instruction, and sw writes no register.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: beq (opcode 4) and bne (opcode 5) go to PC+4 plus the sign-extended offset shifted left by 2 when their two registers are equal (beq) or unequal (bne). Otherwise they go to PC+4.
- R8: j (opcode 2) and jal (opcode 3) go to {PC+4 bits 31:28, the 26-bit target, 2'b00}. jal also writes PC+4 into register 31.
- R9: jr (opcode 0, function 8) sets the program counter to the value of the register in bits 25:21.
- R10: An instruction whose destination is also one of its sources reads the value held before that instruction and writes its result exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Program counter, byte address of the current instruction |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address (base plus offset) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled at the rising edge |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, combinational |

## Verification
Two functions meet in one cycle in two places. The first is an operand read of a register that the same instruction writes back. The second is a jal, which writes the link register while it redirects the program counter. The bench provokes the first with an increment of a register into itself and with a counted backward-branch loop whose counter both feeds and receives each update. It provokes the second with a call into a subroutine that returns through jr. It judges both only at the data port, after the program has stored its registers to memory: an incremented value off by one, a wrong loop total, a missing return or a wrong stored link address each appear as a mismatched word.

// File: rtl/risc_core.sv
module risc_next_pc (
  input  logic [31:0] pc,
  input  logic [15:0] imm,
  input  logic [25:0] target,
  input  logic [31:0] reg_val,
  input  logic        take_branch,
  input  logic        do_jump,
  input  logic        do_jreg,
  output logic [31:0] pc_plus4,
  output logic [31:0] next_pc
);
  logic [31:0] br_off;

  assign pc_plus4 = pc + 32'd4;
  assign br_off   = {{14{imm[15]}}, imm, 2'b00};

  always_comb begin
    if (do_jreg)          next_pc = reg_val;
    else if (do_jump)     next_pc = {pc_plus4[31:28], target, 2'b00};
    else if (take_branch) next_pc = pc_plus4 + br_off;
    else                  next_pc = pc_plus4;
  end
endmodule

module risc_core #(
  parameter logic [31:0] RESET_PC = 32'd0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam logic [5:0] OP_R = 6'd0, OP_J = 6'd2, OP_JAL = 6'd3, OP_BEQ = 6'd4,
                         OP_BNE = 6'd5, OP_ADDI = 6'd8, OP_SLTI = 6'd10, OP_ANDI = 6'd12,
                         OP_ORI = 6'd13, OP_LUI = 6'd15, OP_LW = 6'd35, OP_SW = 6'd43;
  localparam logic [5:0] FN_JR = 6'd8, FN_ADD = 6'd32, FN_SUB = 6'd34, FN_SLT = 6'd42;

  logic [31:0] pc, pc_plus4, next_pc;
  logic [31:0] regs [32];

  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;
  logic [31:0] a, b, imm_s, imm_z;
  logic [31:0] result;
  logic [4:0]  wr_sel;
  logic        wr_en;

  assign op    = imem_data[31:26];
  assign rs    = imem_data[25:21];
  assign rt    = imem_data[20:16];
  assign rd    = imem_data[15:11];
  assign funct = imem_data[5:0];
  assign imm   = imem_data[15:0];
  assign imm_s = {{16{imm[15]}}, imm};
  assign imm_z = {16'd0, imm};

  assign a = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign b = (rt == 5'd0) ? 32'd0 : regs[rt];

  always_comb begin
    result = 32'd0;
    wr_en  = 1'b0;
    wr_sel = rt;
    unique case (op)
      OP_R: begin
        wr_sel = rd;
        case (funct)
          FN_ADD: begin result = a + b; wr_en = 1'b1; end
          FN_SUB: begin result = a - b; wr_en = 1'b1; end
          FN_SLT: begin result = {31'd0, $signed(a) < $signed(b)}; wr_en = 1'b1; end
          default: ;
        endcase
      end
      OP_ADDI: begin result = a + imm_s; wr_en = 1'b1; end
      OP_SLTI: begin result = {31'd0, $signed(a) < $signed(imm_s)}; wr_en = 1'b1; end
      OP_ANDI: begin result = a & imm_z; wr_en = 1'b1; end
      OP_ORI:  begin result = a | imm_z; wr_en = 1'b1; end
      OP_LUI:  begin result = {imm, 16'd0}; wr_en = 1'b1; end
      OP_LW:   begin result = dmem_rdata; wr_en = 1'b1; end
      OP_JAL:  begin result = pc_plus4; wr_en = 1'b1; wr_sel = 5'd31; end
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (wr_en && wr_sel != 5'd0) regs[wr_sel] <= result;

  risc_next_pc u_npc (
    .pc          (pc),
    .imm         (imm),
    .target      (imem_data[25:0]),
    .reg_val     (a),
    .take_branch ((op == OP_BEQ && a == b) || (op == OP_BNE && a != b)),
    .do_jump     (op == OP_J || op == OP_JAL),
    .do_jreg     (op == OP_R && funct == FN_JR),
    .pc_plus4    (pc_plus4),
    .next_pc     (next_pc)
  );

  always_ff @(posedge clk)
    if (rst) pc <= RESET_PC;
    else     pc <= next_pc;

  assign imem_addr  = pc;
  assign dmem_addr  = a + imm_s;
  assign dmem_wdata = b;
  assign dmem_we    = !rst && op == OP_SW;
endmodule

// File: rtl/risc_core_chk.sv
module risc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_data,
  input logic [31:0] dmem_addr,
  input logic        dmem_we
);
  logic [5:0]  op;
  logic [31:0] pc4;
  logic        plain;

  assign op    = imem_data[31:26];
  assign pc4   = imem_addr + 32'd4;
  assign plain = !(op inside {6'd2, 6'd3, 6'd4, 6'd5}) && !(op == 6'd0 && imem_data[5:0] == 6'd8);

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> imem_addr == 32'd0);

  p_seq_pc_r1: assert property (@(posedge clk) disable iff (rst)
    plain |=> imem_addr == $past(imem_addr) + 32'd4);

  p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 6'd43);

  p_zero_base_r6: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'd35 || op == 6'd43) && imem_data[25:21] == 5'd0)
      |-> dmem_addr == {{16{imem_data[15]}}, imem_data[15:0]});

  p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2 || op == 6'd3)
      |=> imem_addr == {$past(pc4[31:28]), $past(imem_data[25:0]), 2'b00});
endmodule

bind risc_core risc_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .imem_data (imem_data),
  .dmem_addr (dmem_addr),
  .dmem_we   (dmem_we)
);

// File: tb/risc_core_tb.sv
module risc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int checks = 0, errors = 0, stores = 0;

  always #5 clk = ~clk;

  risc_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk)
    if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      stores <= stores + 1;
    end

  function automatic logic [31:0] fi(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] fr(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] fj(int op, int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    logic [31:0] neg5, andv, subv;
    int cyc;
    for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
    dmem[8]  = 32'hDEAD0000;
    dmem[16] = 32'hAAAA1111;
    dmem[17] = 32'h5555BBBB;

    imem[0]  = fi(15, 0, 1, 16'h1234);
    imem[1]  = fi(13, 1, 1, 16'h8765);
    imem[2]  = fi(43, 0, 1, 0);
    imem[3]  = fi(8, 0, 2, -5);
    imem[4]  = fi(43, 0, 2, 4);
    imem[5]  = fi(12, 2, 3, 16'hF0F0);
    imem[6]  = fi(43, 0, 3, 8);
    imem[7]  = fi(10, 2, 4, -4);
    imem[8]  = fi(43, 0, 4, 12);
    imem[9]  = fr(3, 2, 5, 42);
    imem[10] = fr(2, 3, 6, 42);
    imem[11] = fr(3, 2, 7, 34);
    imem[12] = fr(7, 4, 8, 32);
    imem[13] = fi(43, 0, 5, 16);
    imem[14] = fi(43, 0, 6, 20);
    imem[15] = fi(43, 0, 7, 24);
    imem[16] = fi(43, 0, 8, 28);
    imem[17] = fi(8, 0, 0, 7);
    imem[18] = fi(43, 0, 0, 32);
    imem[19] = fi(8, 0, 9, 3);
    imem[20] = fi(8, 9, 9, 1);
    imem[21] = fi(43, 0, 9, 36);
    imem[22] = fi(8, 0, 10, 64);
    imem[23] = fi(35, 10, 11, 0);
    imem[24] = fi(35, 10, 12, 4);
    imem[25] = fi(43, 10, 12, 0);
    imem[26] = fi(43, 10, 11, 4);
    imem[27] = fi(8, 0, 13, 0);
    imem[28] = fi(4, 4, 6, 1);
    imem[29] = fi(8, 13, 13, 1);
    imem[30] = fi(5, 4, 6, 1);
    imem[31] = fi(8, 13, 13, 2);
    imem[32] = fi(5, 4, 5, 1);
    imem[33] = fi(8, 13, 13, 4);
    imem[34] = fi(43, 0, 13, 40);
    imem[35] = fi(8, 0, 14, 0);
    imem[36] = fi(8, 0, 15, 3);
    imem[37] = fi(8, 14, 14, 5);
    imem[38] = fi(8, 15, 15, -1);
    imem[39] = fi(5, 15, 0, -3);
    imem[40] = fi(43, 0, 14, 44);
    imem[41] = fj(3, 50);
    imem[42] = fi(43, 0, 16, 48);
    imem[43] = fj(2, 60);
    imem[50] = fi(8, 0, 16, 16'h77);
    imem[51] = fr(31, 0, 0, 8);
    imem[60] = fi(43, 0, 31, 52);
    imem[61] = fj(2, 61);

    repeat (3) @(negedge clk);
    chk("R1 reset pc", imem_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 advance", imem_addr, 32'd4);

    cyc = 0;
    while (imem_addr != 32'd244 && cyc < 2000) begin @(negedge clk); cyc++; end
    if (cyc >= 2000) begin
      errors++;
      $display("FAIL watchdog actual %h expected %h", imem_addr, 32'd244);
    end
    repeat (3) @(negedge clk);

    neg5 = 32'd0 - 32'd5;
    andv = neg5 & 32'h0000F0F0;
    subv = andv - neg5;
    chk("R4 lui+ori", dmem[0], (32'h1234 << 16) | 32'h8765);
    chk("R3 addi sext", dmem[1], neg5);
    chk("R3 andi zext", dmem[2], andv);
    chk("R3 slti", dmem[3], 32'd1);
    chk("R2 slt false", dmem[4], 32'd0);
    chk("R2 slt true", dmem[5], 32'd1);
    chk("R2 sub", dmem[6], subv);
    chk("R2 add", dmem[7], subv + 32'd1);
    chk("R6 r0 stays zero", dmem[8], 32'd0);
    chk("R10 self increment", dmem[9], 32'd3 + 32'd1);
    chk("R5 swap lo", dmem[16], 32'h5555BBBB);
    chk("R5 swap hi", dmem[17], 32'hAAAA1111);
    chk("R7 branch mix", dmem[10], 32'd2);
    chk("R7 R10 loop", dmem[11], 32'd3 * 32'd5);
    chk("R9 jr return", dmem[12], 32'h77);
    chk("R8 jal link", dmem[13], 32'd42 * 32'd4);
    chk("R5 store count", stores, 32'd16);
    chk("R8 halt loop", imem_addr, 32'd61 * 32'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule